// File: doc/BRIEF.md
# Programming-Mode Word Address Pointer

This block keeps the word address used while a small microcontroller sits in program/verify mode. The address is 14 bits wide. The lower half (0000h–1FFFh) is user program space and the upper half (2000h–3FFFh) is configuration space. An increment strobe steps the pointer, and each half wraps onto its own base. A jump strobe moves the pointer to 2000h and locks it in configuration space. Only a reset brings it back to user space.

The physical stores are far smaller than the logical space, so each address is folded onto one of them:
- The user array has 1K words and is indexed by the low ten address bits.
- The configuration array has 16 words at 2000h–200Fh. Of these, 2000h–2003h hold ID words, 2007h holds the configuration word, and the rest are reserved.
- Configuration-space addresses above 200Fh fall through to the user array.

Both arrays are included as 14-bit register stores that model the erased state (3FFFh) after reset. Each store has a combinational read and a clocked write.

Top module: `prog_addr_unit`

## Requirements
- R1: While rst_ni is low, and after it is released, addr_o is 0000h and cfg_lock_o is 0. Every word of both arrays reads back 3FFFh.
- R2: When cfg_lock_o is 0, an inc_i cycle without cfg_jump_i advances addr_o by one on the next rising edge. 1FFFh steps to 0000h.
- R3: A cfg_jump_i cycle sets addr_o to 2000h and cfg_lock_o to 1 on the next rising edge. This happens whether or not inc_i is also high.
- R4: While cfg_lock_o is 1, bit 13 of addr_o stays 1 and inc_i steps the low 13 bits. 3FFFh steps to 2000h.
- R5: For addresses below 2000h, sel_cfg_o is 0 and phys_idx_o equals addr_o[9:0]. Addresses 0400h and above alias onto the same user words.
- R6: For 2000h–200Fh, sel_cfg_o is 1 and phys_idx_o equals addr_o[3:0]. For 2010h–3FFFh, sel_cfg_o is 0 and phys_idx_o equals addr_o[9:0], which is a user word.
- R7: id_loc_o is 1 exactly at 2000h–2003h, and cfg_word_o is 1 exactly at 2007h. reserved_o is 1 exactly at 2004h–2006h and 2008h–200Fh. avail_o is 1 below 2000h and wherever id_loc_o or cfg_word_o is 1.
- R8: A wr_en_i cycle on a non-reserved location stores wr_data_i in the selected array word. rd_data_o then shows that word from the next edge.
- R9: A write to a reserved location changes nothing, and rd_data_o is 3FFFh whenever reserved_o is 1.
- R10: With inc_i and cfg_jump_i low, addr_o and cfg_lock_o hold their values across clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; entering programming mode |
| inc_i | input | 1 | Step the address pointer |
| cfg_jump_i | input | 1 | Jump to 2000h and lock into configuration space |
| wr_en_i | input | 1 | Write wr_data_i to the current location |
| wr_data_i | input | 14 | Write data |
| addr_o | output | 14 | Current logical address |
| cfg_lock_o | output | 1 | Pointer is locked in configuration space |
| sel_cfg_o | output | 1 | 1: configuration array selected, 0: user array |
| phys_idx_o | output | 10 | Word index inside the selected array |
| avail_o | output | 1 | Location is usable |
| reserved_o | output | 1 | Location is a reserved configuration word |
| id_loc_o | output | 1 | Location is an ID word |
| cfg_word_o | output | 1 | Location is the configuration word |
| rd_data_o | output | 14 | Word read from the current location |

## Verification
The hardest case to reach is a configuration-space address above 200Fh reading real user data. The pointer cannot go back to user space once locked, and reset erases both arrays. The stimulus therefore writes a pattern at user word 010h first, then jumps and steps sixteen times to 2010h, where that pattern must appear. Both wrap points need long increment runs: about 8K steps through user space to 1FFFh, and about 8K steps through configuration space to 3FFFh.

// File: rtl/prog_addr_pkg.sv
package prog_addr_pkg;
  localparam int ADDR_W   = 14;
  localparam int DATA_W   = 14;
  localparam int USER_AW  = 10;
  localparam int CFG_AW   = 4;
  localparam int ID_N     = 4;
  localparam int CFGW_IDX = 7;
  localparam logic [DATA_W-1:0] ERASED = '1;

  typedef struct packed {
    logic sel_cfg;
    logic is_id;
    logic is_cfgw;
    logic is_rsvd;
    logic avail;
  } loc_info_t;
endpackage

// File: rtl/prog_addr_ptr.sv
module prog_addr_ptr #(
  parameter int AW = prog_addr_pkg::ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          jump_i,
  output logic [AW-1:0] addr_o,
  output logic          lock_o
);
  localparam int LW = AW - 1;
  localparam logic [AW-1:0] CFG_BASE = AW'(1) << LW;

  logic [AW-1:0] addr_q;
  logic          lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      lock_q <= 1'b0;
    end else if (jump_i) begin
      addr_q <= CFG_BASE;
      lock_q <= 1'b1;
    end else if (inc_i) begin
      // each half wraps within itself; lock pins the top bit
      addr_q <= {addr_q[AW-1] | lock_q, addr_q[LW-1:0] + 1'b1};
    end
  end

  assign addr_o = addr_q;
  assign lock_o = lock_q;

  a_r4_lock_keeps_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |-> addr_q[AW-1]);
  a_r3_jump_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_i |=> (addr_q == CFG_BASE) && lock_q);
  a_r2_user_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !jump_i && !lock_q) |=> (addr_q == {1'b0, $past(addr_q[LW-1:0]) + 1'b1}));
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !jump_i) |=> ($stable(addr_q) && $stable(lock_q)));
endmodule

// File: rtl/prog_addr_decode.sv
module prog_addr_decode #(
  parameter int AW       = prog_addr_pkg::ADDR_W,
  parameter int UAW      = prog_addr_pkg::USER_AW,
  parameter int CAW      = prog_addr_pkg::CFG_AW,
  parameter int ID_N     = prog_addr_pkg::ID_N,
  parameter int CFGW_IDX = prog_addr_pkg::CFGW_IDX
) (
  input  logic [AW-1:0]            addr_i,
  output prog_addr_pkg::loc_info_t info_o,
  output logic [UAW-1:0]           idx_o
);
  logic           in_cfg, cfg_hit;
  logic [CAW-1:0] low;

  assign in_cfg  = addr_i[AW-1];
  assign cfg_hit = in_cfg && (addr_i[AW-2:CAW] == '0);
  assign low     = addr_i[CAW-1:0];

  always_comb begin
    info_o.sel_cfg = cfg_hit;
    info_o.is_id   = cfg_hit && (low < CAW'(ID_N));
    info_o.is_cfgw = cfg_hit && (low == CAW'(CFGW_IDX));
    info_o.is_rsvd = cfg_hit && !info_o.is_id && !info_o.is_cfgw;
    info_o.avail   = !in_cfg || info_o.is_id || info_o.is_cfgw;
    // above the implemented config window the user array is reached
    idx_o          = cfg_hit ? UAW'(low) : addr_i[UAW-1:0];
  end
endmodule

// File: rtl/prog_word_store.sv
module prog_word_store #(
  parameter int              DW    = prog_addr_pkg::DATA_W,
  parameter int              IW    = prog_addr_pkg::USER_AW,
  parameter logic [DW-1:0]   INIT  = '1,
  localparam int             DEPTH = 1 << IW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= INIT;
    end else if (we_i) begin
      mem_q[idx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/prog_addr_unit.sv
module prog_addr_unit #(
  parameter int AW  = prog_addr_pkg::ADDR_W,
  parameter int DW  = prog_addr_pkg::DATA_W,
  parameter int UAW = prog_addr_pkg::USER_AW,
  parameter int CAW = prog_addr_pkg::CFG_AW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           inc_i,
  input  logic           cfg_jump_i,
  input  logic           wr_en_i,
  input  logic [DW-1:0]  wr_data_i,
  output logic [AW-1:0]  addr_o,
  output logic           cfg_lock_o,
  output logic           sel_cfg_o,
  output logic [UAW-1:0] phys_idx_o,
  output logic           avail_o,
  output logic           reserved_o,
  output logic           id_loc_o,
  output logic           cfg_word_o,
  output logic [DW-1:0]  rd_data_o
);
  localparam logic [DW-1:0] ERASED = '1;

  prog_addr_pkg::loc_info_t info;
  logic [AW-1:0]  addr;
  logic [UAW-1:0] idx;
  logic [DW-1:0]  user_rd, cfg_rd;
  logic           we_user, we_cfg;

  prog_addr_ptr #(.AW(AW)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (inc_i),
    .jump_i (cfg_jump_i),
    .addr_o (addr),
    .lock_o (cfg_lock_o)
  );

  prog_addr_decode #(.AW(AW), .UAW(UAW), .CAW(CAW)) u_dec (
    .addr_i (addr),
    .info_o (info),
    .idx_o  (idx)
  );

  assign we_user = wr_en_i && !info.sel_cfg;
  assign we_cfg  = wr_en_i && info.sel_cfg && !info.is_rsvd;

  prog_word_store #(.DW(DW), .IW(UAW), .INIT(ERASED)) u_user (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_user),
    .idx_i   (idx),
    .wdata_i (wr_data_i),
    .rdata_o (user_rd)
  );

  prog_word_store #(.DW(DW), .IW(CAW), .INIT(ERASED)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_cfg),
    .idx_i   (idx[CAW-1:0]),
    .wdata_i (wr_data_i),
    .rdata_o (cfg_rd)
  );

  assign addr_o     = addr;
  assign sel_cfg_o  = info.sel_cfg;
  assign phys_idx_o = idx;
  assign avail_o    = info.avail;
  assign reserved_o = info.is_rsvd;
  assign id_loc_o   = info.is_id;
  assign cfg_word_o = info.is_cfgw;
  assign rd_data_o  = info.is_rsvd ? ERASED : (info.sel_cfg ? cfg_rd : user_rd);

  a_r9_rsvd_reads_erased: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reserved_o |-> (rd_data_o == ERASED));
  a_r7_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({id_loc_o, cfg_word_o, reserved_o}));
  a_r6_cfg_sel_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_cfg_o |-> addr_o[AW-1]);
  a_r8_write_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !reserved_o && !inc_i && !cfg_jump_i) |=> (rd_data_o == $past(wr_data_i)));
endmodule

// File: tb/tb_prog_addr_unit.sv
`timescale 1ns/1ps
module tb_prog_addr_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        inc_i = 1'b0, cfg_jump_i = 1'b0, wr_en_i = 1'b0;
  logic [13:0] wr_data_i = '0;
  logic [13:0] addr_o, rd_data_o;
  logic [9:0]  phys_idx_o;
  logic        cfg_lock_o, sel_cfg_o, avail_o, reserved_o, id_loc_o, cfg_word_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  prog_addr_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(inc_i), .cfg_jump_i(cfg_jump_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .addr_o(addr_o),
    .cfg_lock_o(cfg_lock_o), .sel_cfg_o(sel_cfg_o), .phys_idx_o(phys_idx_o),
    .avail_o(avail_o), .reserved_o(reserved_o), .id_loc_o(id_loc_o),
    .cfg_word_o(cfg_word_o), .rd_data_o(rd_data_o)
  );

  // op: 0 idle, 1 inc, 2 jump, 3 inc+jump, 4 write
  typedef struct packed {
    logic [2:0]  op;
    logic [13:0] wd;
    logic [13:0] ea;
    logic [13:0] er;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{3'd4, 14'h00AA, 14'h0000, 14'h00AA},
    '{3'd1, 14'h0000, 14'h0001, 14'h3FFF},
    '{3'd4, 14'h0155, 14'h0001, 14'h0155},
    '{3'd0, 14'h0000, 14'h0001, 14'h0155},
    '{3'd1, 14'h0000, 14'h0002, 14'h3FFF},
    '{3'd3, 14'h0000, 14'h2000, 14'h3FFF},
    '{3'd4, 14'h3F85, 14'h2000, 14'h3F85},
    '{3'd1, 14'h0000, 14'h2001, 14'h3FFF},
    '{3'd1, 14'h0000, 14'h2002, 14'h3FFF},
    '{3'd1, 14'h0000, 14'h2003, 14'h3FFF},
    '{3'd1, 14'h0000, 14'h2004, 14'h3FFF},
    '{3'd4, 14'h0000, 14'h2004, 14'h3FFF},
    '{3'd1, 14'h0000, 14'h2005, 14'h3FFF},
    '{3'd1, 14'h0000, 14'h2006, 14'h3FFF},
    '{3'd1, 14'h0000, 14'h2007, 14'h3FFF},
    '{3'd4, 14'h3FF2, 14'h2007, 14'h3FF2},
    '{3'd1, 14'h0000, 14'h2008, 14'h3FFF},
    '{3'd4, 14'h0001, 14'h2008, 14'h3FFF},
    '{3'd2, 14'h0000, 14'h2000, 14'h3F85}
  };

  task automatic chk(input string tag, input logic [13:0] act, input logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic i, input logic j, input logic w, input logic [13:0] d);
    inc_i = i; cfg_jump_i = j; wr_en_i = w; wr_data_i = d;
    @(negedge clk_i);
    inc_i = 1'b0; cfg_jump_i = 1'b0; wr_en_i = 1'b0;
  endtask

  task automatic inc_n(input int n);
    for (int k = 0; k < n; k++) cyc(1'b1, 1'b0, 1'b0, '0);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    #3;
    chk("R1 addr in reset", addr_o, 14'h0000);
    chk("R1 lock in reset", {13'b0, cfg_lock_o}, 14'h0000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic exp_id, exp_cw, exp_rs;
    do_reset();
    chk("R1 addr after reset", addr_o, 14'h0000);
    chk("R1 erased read", rd_data_o, 14'h3FFF);

    // table: R2 R3 R7 R8 R9 R10
    for (int v = 0; v < NV; v++) begin
      case (VECS[v].op)
        3'd1: cyc(1'b1, 1'b0, 1'b0, '0);
        3'd2: cyc(1'b0, 1'b1, 1'b0, '0);
        3'd3: cyc(1'b1, 1'b1, 1'b0, '0);
        3'd4: cyc(1'b0, 1'b0, 1'b1, VECS[v].wd);
        default: cyc(1'b0, 1'b0, 1'b0, '0);
      endcase
      chk($sformatf("R2/R3/R10 vec%0d addr", v), addr_o, VECS[v].ea);
      chk($sformatf("R8/R9 vec%0d data", v), rd_data_o, VECS[v].er);
    end
    chk("R3 lock after jump", {13'b0, cfg_lock_o}, 14'h0001);

    // R6 R7: walk the implemented configuration window
    for (int k = 0; k < 16; k++) begin
      exp_id = (k < 4);
      exp_cw = (k == 7);
      exp_rs = !exp_id && !exp_cw;
      chk($sformatf("R6 sel @%0d", k), {13'b0, sel_cfg_o}, 14'h0001);
      chk($sformatf("R6 idx @%0d", k), {4'b0, phys_idx_o}, 14'(k));
      chk($sformatf("R7 id @%0d", k), {13'b0, id_loc_o}, {13'b0, exp_id});
      chk($sformatf("R7 cfgword @%0d", k), {13'b0, cfg_word_o}, {13'b0, exp_cw});
      chk($sformatf("R7 reserved @%0d", k), {13'b0, reserved_o}, {13'b0, exp_rs});
      chk($sformatf("R7 avail @%0d", k), {13'b0, avail_o}, {13'b0, !exp_rs});
      if (exp_rs) chk($sformatf("R9 erased @%0d", k), rd_data_o, 14'h3FFF);
      inc_n(1);
    end
    chk("R6 addr 2010h", addr_o, 14'h2010);
    chk("R6 fall to user sel", {13'b0, sel_cfg_o}, 14'h0000);
    chk("R6 fall to user idx", {4'b0, phys_idx_o}, 14'h0010);
    chk("R7 avail above window", {13'b0, avail_o}, 14'h0000);

    // R1: reset leaves config space and erases stores
    do_reset();
    chk("R1 lock cleared", {13'b0, cfg_lock_o}, 14'h0000);
    chk("R1 user word erased", rd_data_o, 14'h3FFF);

    // R5 aliasing, R2 wrap
    inc_n(16);
    cyc(1'b0, 1'b0, 1'b1, 14'h2A5A);
    chk("R8 user write", rd_data_o, 14'h2A5A);
    chk("R5 user sel", {13'b0, sel_cfg_o}, 14'h0000);
    inc_n(1024);
    chk("R5 alias addr", addr_o, 14'h0410);
    chk("R5 alias idx", {4'b0, phys_idx_o}, 14'h0010);
    chk("R5 alias data", rd_data_o, 14'h2A5A);
    inc_n(14'h1FFF - 14'h0410);
    chk("R2 reach 1FFFh", addr_o, 14'h1FFF);
    chk("R2 no lock", {13'b0, cfg_lock_o}, 14'h0000);
    inc_n(1);
    chk("R2 wrap to 0000h", addr_o, 14'h0000);

    // R6: above the window reads user data
    cyc(1'b0, 1'b1, 1'b0, '0);
    inc_n(16);
    chk("R6 2010h addr", addr_o, 14'h2010);
    chk("R6 2010h user data", rd_data_o, 14'h2A5A);

    // R4: wrap inside configuration space
    inc_n(14'h3FFF - 14'h2010);
    chk("R4 reach 3FFFh", addr_o, 14'h3FFF);
    chk("R4 lock held", {13'b0, cfg_lock_o}, 14'h0001);
    inc_n(1);
    chk("R4 wrap to 2000h", addr_o, 14'h2000);
    chk("R4 id after wrap", {13'b0, id_loc_o}, 14'h0001);

    // R10: idle cycles hold the pointer
    cyc(1'b0, 1'b0, 1'b0, '0);
    cyc(1'b0, 1'b0, 1'b0, '0);
    chk("R10 hold", addr_o, 14'h2000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule